// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine moves received frames from a byte stream into memory buffers that software hands it through a ring of descriptors. Each descriptor is two 32-bit words. The first word holds the buffer address in bits [31:2], a wrap flag in bit 1 and an ownership flag in bit 0. The second word is a status word that the engine fills in. Software clears the ownership flag to give a descriptor to the engine. The engine sets the flag again once the buffer holds data and the status word is valid.

When a frame begins, the engine reads the first word of the current descriptor. If that descriptor is free, the engine packs the frame bytes into 32-bit words and writes them to the buffer. It then writes the status word and finally rewrites the first word with the ownership flag set. After that it moves to the next descriptor, or returns to the ring base if the wrap flag was set. A frame larger than one buffer continues into the following descriptors. If the engine finds a descriptor still owned by software, it discards the rest of the frame and raises a sticky "no buffer" flag.

The controller has these states:
- IDLE: waiting. It reloads the ring position from `ring_base` while reception is off.
- FETCH: issues the descriptor read.
- CHECK: inspects the ownership flag. It goes to FILL if the descriptor is free and to DROP if not.
- FILL: accepts bytes. It goes to PUT_DATA when a word is complete or the frame ends.
- PUT_DATA: writes the word, then returns to FILL or goes to PUT_STAT.
- PUT_STAT: writes the status word.
- PUT_OWN: hands the descriptor back, then goes to IDLE or to FETCH to spill the frame into the next descriptor.
- DROP: discards bytes until the last one, then returns to IDLE.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset `in_ready`, `mem_we`, `mem_rd` and `buf_unavail` are 0.
- R2: While `rx_en` is 0 and no frame is in progress, `in_ready` stays 0, the memory port is not used, and the ring position is reloaded from `ring_base`. A frame is started only when `rx_en` is 1 at its first byte.
- R3: At frame start the engine reads word 0 of the current descriptor. If bit 0 is 0, it stores the frame bytes from address (word 0 AND 0xFFFFFFFC) upward, little-endian within each word (the first byte in bits [7:0]). A partial final word is written with byte enables for the used lanes only.
- R4: After a buffer's data, the engine writes the status word at descriptor+4. Bits [13:0] hold the number of bytes stored in this buffer, bit 14 is set for the first buffer of a frame, bit 15 is set for the buffer holding the last byte, and all other bits are 0.
- R5: After the status word, the engine rewrites word 0 with the same bits [31:1] and bit 0 set to 1. This is the last write made for that descriptor.
- R6: The next descriptor lies 8 bytes further on, or at `ring_base` when bit 1 of the used descriptor's word 0 was 1.
- R7: A frame longer than BUF_BYTES fills whole buffers of BUF_BYTES bytes and continues into the following descriptors. Only the first of these buffers carries the start flag and only the last carries the end flag.
- R8: If the descriptor at frame start has bit 0 set, the whole frame is accepted and discarded with no memory write, `buf_unavail` is set, and the ring position does not move.
- R9: If a spilling frame meets a descriptor with bit 0 set, the rest of the frame is discarded and `buf_unavail` is set. The buffers already filled stay handed over, the last of them without the end flag, and the ring position stays on the owned descriptor.
- R10: `buf_unavail` stays 1 until a cycle with `buf_unavail_clr` high.
- R11: Memory writes are word aligned and never share a cycle with a descriptor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Reception enable |
| ring_base | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the frame's last |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_rd | output | 1 | Descriptor read request; data is returned on `mem_rd_data` the next cycle |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | 32 | Byte address for a read or a write |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for the write |
| mem_rd_data | input | 32 | Read data, one cycle after `mem_rd` |
| buf_unavail | output | 1 | Sticky flag: a frame, or part of one, was dropped because no descriptor was free |
| buf_unavail_clr | input | 1 | Clears `buf_unavail` |

## Verification
The hardest case to reach is the spill path: a frame has already filled one buffer and then finds the next descriptor still owned by software. The bench gets there by freeing exactly one descriptor, leaving its neighbour owned, and sending a frame longer than one buffer. It then frees that neighbour and sends another frame to confirm that the ring position did not move. A sweep of frame lengths from 1 to three buffers on a four-descriptor ring covers every partial-word lane count, exact buffer fills and wrap-around.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int WORD_BYTES  = 4;
    localparam int DESC_STRIDE = 8;
    localparam int LEN_W       = 14;
    localparam int OWN_BIT     = 0;
    localparam int WRAP_BIT    = 1;
    localparam int SOF_BIT     = 14;
    localparam int EOF_BIT     = 15;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_FILL,
        S_PUT_DATA,
        S_PUT_STAT,
        S_PUT_OWN,
        S_DROP
    } rxd_state_e;
endpackage

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
    parameter int WORD_BYTES = 4,
    localparam int LANE_W = $clog2(WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    take,
    input  logic [7:0]              byte_in,
    output logic [8*WORD_BYTES-1:0] word_q,
    output logic [WORD_BYTES-1:0]   be_q,
    output logic [LANE_W-1:0]       lane_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            be_q   <= '0;
            lane_q <= '0;
        end else if (clr) begin
            word_q <= '0;
            be_q   <= '0;
            lane_q <= '0;
        end else if (take) begin
            word_q[8*lane_q +: 8] <= byte_in;
            be_q[lane_q]          <= 1'b1;
            lane_q                <= lane_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
    parameter int STRIDE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reload,
    input  logic        advance,
    input  logic        wrap,
    input  logic [31:0] base,
    output logic [31:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (reload) begin
            ptr <= base;
        end else if (advance) begin
            ptr <= wrap ? base : ptr + 32'(STRIDE);
        end
    end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES = 1536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic [31:0] ring_base,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        mem_rd,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic [31:0] mem_rd_data,
    output logic        buf_unavail,
    input  logic        buf_unavail_clr
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam logic [CNT_W-1:0] BUF_FULL = CNT_W'(BUF_BYTES);
    localparam int LANE_W = $clog2(WORD_BYTES);

    rxd_state_e state, state_nx;

    logic [31:0]      buf_addr;
    logic             wrap_q;
    logic [CNT_W-1:0] byte_cnt;
    logic             first_q;
    logic             last_q;
    logic [31:0]      desc_ptr;
    logic [31:0]      word_q;
    logic [3:0]       be_q;
    logic [LANE_W-1:0] lane_q;
    logic             accept;
    logic             go;
    logic [CNT_W-1:0] last_idx;
    logic [31:0]      data_addr;
    logic [31:0]      stat_word;

    assign accept   = (state == S_FILL) && in_valid;
    assign go       = rx_en && in_valid;
    assign last_idx = byte_cnt - 1'b1;
    assign data_addr = buf_addr + 32'({last_idx[CNT_W-1:2], 2'b00});

    always_comb begin
        stat_word = '0;
        stat_word[LEN_W-1:0] = LEN_W'(byte_cnt);
        stat_word[SOF_BIT]   = first_q;
        stat_word[EOF_BIT]   = last_q;
    end

    rxd_byte_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == S_PUT_DATA),
        .take    (accept),
        .byte_in (in_data),
        .word_q  (word_q),
        .be_q    (be_q),
        .lane_q  (lane_q)
    );

    rxd_ring_ptr #(.STRIDE(DESC_STRIDE)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  ((state == S_IDLE) && !rx_en),
        .advance (state == S_PUT_OWN),
        .wrap    (wrap_q),
        .base    (ring_base),
        .ptr     (desc_ptr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (go) state_nx = S_FETCH;
            S_FETCH:    state_nx = S_CHECK;
            S_CHECK:    state_nx = mem_rd_data[OWN_BIT] ? S_DROP : S_FILL;
            S_FILL:     if (accept && (lane_q == LANE_W'(WORD_BYTES - 1) || in_last))
                            state_nx = S_PUT_DATA;
            S_PUT_DATA: state_nx = (last_q || byte_cnt == BUF_FULL) ? S_PUT_STAT : S_FILL;
            S_PUT_STAT: state_nx = S_PUT_OWN;
            S_PUT_OWN:  state_nx = last_q ? S_IDLE : S_FETCH;
            S_DROP:     if (in_valid && in_last) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_addr    <= '0;
            wrap_q      <= 1'b0;
            byte_cnt    <= '0;
            first_q     <= 1'b0;
            last_q      <= 1'b0;
            buf_unavail <= 1'b0;
        end else begin
            if (buf_unavail_clr) buf_unavail <= 1'b0;
            unique case (state)
                S_IDLE: if (go) begin
                    first_q <= 1'b1;
                    last_q  <= 1'b0;
                end
                S_CHECK: begin
                    if (mem_rd_data[OWN_BIT]) begin
                        buf_unavail <= 1'b1;
                    end else begin
                        buf_addr <= {mem_rd_data[31:2], 2'b00};
                        wrap_q   <= mem_rd_data[WRAP_BIT];
                        byte_cnt <= '0;
                    end
                end
                S_FILL: if (accept) begin
                    byte_cnt <= byte_cnt + 1'b1;
                    last_q   <= in_last;
                end
                S_PUT_OWN: first_q <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        unique case (state)
            S_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = desc_ptr;
            end
            S_FILL, S_DROP: in_ready = 1'b1;
            S_PUT_DATA: begin
                mem_we    = 1'b1;
                mem_addr  = data_addr;
                mem_wdata = word_q;
                mem_be    = be_q;
            end
            S_PUT_STAT: begin
                mem_we    = 1'b1;
                mem_addr  = desc_ptr + 32'd4;
                mem_wdata = stat_word;
                mem_be    = 4'hF;
            end
            S_PUT_OWN: begin
                mem_we    = 1'b1;
                mem_addr  = desc_ptr;
                mem_wdata = {buf_addr[31:2], wrap_q, 1'b1};
                mem_be    = 4'hF;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input rxd_state_e       state,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             in_ready,
    input logic             mem_rd,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_rd_data,
    input logic             buf_unavail
);
    assert_no_rd_wr_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    assert_word_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));

    assert_own_after_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == S_PUT_OWN) |-> ($past(mem_we) && $past(mem_addr) == mem_addr + 32'd4));

    assert_unavail_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_unavail) |-> $past(state == S_CHECK && mem_rd_data[OWN_BIT]));

    assert_quiet_port_while_accepting_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!mem_we && !mem_rd));

    assert_buffer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL) |-> (byte_cnt < CNT_W'(BUF_BYTES)));
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .byte_cnt    (byte_cnt),
    .in_ready    (in_ready),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .buf_unavail (buf_unavail)
);

// File: tb/rxd_ring_writer_test.sv
module rxd_ring_writer_test;
    localparam int BUF = 8;
    localparam int ND  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [31:0] ring_base = 32'h0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_rd, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rd_data;
    logic        buf_unavail;
    logic        buf_unavail_clr = 1'b0;

    always #2 clk = ~clk;

    rxd_ring_writer #(.BUF_BYTES(BUF)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rd_data(mem_rd_data),
        .buf_unavail(buf_unavail), .buf_unavail_clr(buf_unavail_clr)
    );

    logic [31:0] mem [256];
    int wr_count = 0, rd_count = 0, misaligned = 0, order_err = 0;
    logic [31:0] prev_wr_addr = 32'hFFFF_FFFF;

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rd_data <= mem[mem_addr[9:2]];
            rd_count <= rd_count + 1;
        end
        if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            wr_count <= wr_count + 1;
            if (mem_addr[1:0] != 2'b00) misaligned <= misaligned + 1;
            if (mem_addr < 32'h40 && mem_addr[2:0] == 3'b000 && mem_wdata[0]
                && prev_wr_addr != mem_addr + 32'd4) order_err <= order_err + 1;
            prev_wr_addr <= mem_addr;
        end
    end

    int checks = 0, failures = 0;
    int p = 0;
    bit own [ND];
    bit exp_unav = 0;
    bit done = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(int f, int k);
        return 8'(f * 37 + k * 5 + 1);
    endfunction

    function automatic logic [31:0] bufaddr(int d);
        return 32'h100 + 32'h10 * d;
    endfunction

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return mem[a[9:2]][8*a[1:0] +: 8];
    endfunction

    task automatic free_desc(int d);
        mem[2*d]     = bufaddr(d) | ((d == ND - 1) ? 32'd2 : 32'd0);
        mem[2*d + 1] = 32'h0;
        for (int w = 0; w < 4; w++) mem[(bufaddr(d) >> 2) + w] = 32'hEEEE_EEEE;
        own[d] = 1'b0;
    endtask

    task automatic take_desc(int d);
        mem[2*d] = mem[2*d] | 32'd1;
        own[d] = 1'b1;
    endtask

    task automatic send(int f, int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = byte_val(f, k);
            in_last  = (k == len - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic verify(int f, int len, string unav_req);
        int rem = len;
        int off = 0;
        bit first = 1'b1;
        int n;
        while (rem > 0) begin
            if (own[p]) begin
                exp_unav = 1'b1;
                break;
            end
            n = (rem < BUF) ? rem : BUF;
            for (int k = 0; k < BUF; k++)
                chk((off > 0) ? "R7" : "R3", 32'(mem_byte(bufaddr(p) + k)),
                    (k < n) ? 32'(byte_val(f, off + k)) : 32'hEE);
            chk("R4", mem[2*p + 1], 32'(n) | (first ? 32'h4000 : 32'h0) | ((rem == n) ? 32'h8000 : 32'h0));
            chk((p == 0 && f > 0) ? "R6" : "R5", mem[2*p],
                bufaddr(p) | ((p == ND - 1) ? 32'd2 : 32'd0) | 32'd1);
            own[p] = 1'b1;
            p = (p == ND - 1) ? 0 : p + 1;
            rem -= n;
            off += n;
            first = 1'b0;
        end
        chk(unav_req, 32'(buf_unavail), 32'(exp_unav));
    endtask

    task automatic free_all();
        for (int d = 0; d < ND; d++) if (own[d]) free_desc(d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int wc, rc;
        for (int i = 0; i < 256; i++) mem[i] = 32'hEEEE_EEEE;
        for (int d = 0; d < ND; d++) free_desc(d);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", 32'(in_ready), 0);
        chk("R1", 32'(mem_we), 0);
        chk("R1", 32'(mem_rd), 0);
        chk("R1", 32'(buf_unavail), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;

        // Sweep of frame lengths over one, two and three buffers
        for (int f = 0; f < 24; f++) begin
            send(f, f + 1);
            verify(f, f + 1, "R8");
            free_all();
        end

        // R8: every descriptor owned at frame start
        for (int d = 0; d < ND; d++) take_desc(d);
        wc = wr_count;
        send(30, 5);
        chk("R8", 32'(buf_unavail), 1);
        chk("R8", 32'(wr_count), 32'(wc));
        repeat (20) @(negedge clk);
        chk("R10", 32'(buf_unavail), 1);
        buf_unavail_clr = 1'b1;
        @(negedge clk);
        buf_unavail_clr = 1'b0;
        chk("R10", 32'(buf_unavail), 0);
        exp_unav = 1'b0;

        // R9: the frame spills into a descriptor still owned
        free_desc(p);
        send(31, 12);
        verify(31, 12, "R9");
        chk("R9", 32'(own[p]), 1);
        buf_unavail_clr = 1'b1;
        @(negedge clk);
        buf_unavail_clr = 1'b0;
        exp_unav = 1'b0;
        free_desc(p);
        send(32, 3);
        verify(32, 3, "R9");
        free_all();

        // R2: disabled engine ignores bytes and reloads the ring position
        @(negedge clk);
        rx_en = 1'b0;
        wc = wr_count;
        rc = rd_count;
        in_valid = 1'b1;
        in_data = 8'h55;
        in_last = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            chk("R2", 32'(in_ready), 0);
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        chk("R2", 32'(wr_count), 32'(wc));
        chk("R2", 32'(rd_count), 32'(rc));
        rx_en = 1'b1;
        p = 0;
        send(33, 6);
        chk("R2", mem[1], 32'h0000_C006);
        verify(33, 6, "R8");
        free_all();

        chk("R11", 32'(misaligned), 0);
        chk("R5", 32'(order_err), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule